// File: doc/BRIEF.md
# Stacked Register Window Allocator

This block hands every procedure a private window of stacked registers taken from a ring of 96 physical slots. A call slides the window base forward past the caller's local registers, so the caller's output registers become the callee's first registers at r32 while the caller's locals drop out of view. A return brings back the caller's window geometry from a small internal LIFO of saved frames. An allocate operation resizes the current window in place.

The ring holds both the live window and the windows of suspended callers. When these no longer fit in 96 slots, the block asks for the oldest resident slot to be written to memory, one slot per acknowledge, and holds off further operations until the window fits. After a return whose caller locals were partly written out, it asks for them back, one slot per acknowledge, the most recently written first. A combinational port translates a virtual register number into a physical register number and flags numbers outside the live window.

Top module: `regstack_alloc`

## Requirements
- R1: After reset the window base is slot 0 and the window is empty: virtual registers 0..31 translate to the same physical number, register 32 is flagged illegal, and no transfer request is raised.
- R2: A virtual register v with 32 <= v < 32+size translates to 32 + ((base + v - 32) mod 96), where size = locals + outputs; any v >= 32+size raises illegal_o.
- R3: An allocate strobe sets the window to loc_i locals and out_i outputs without moving the base.
- R4: A call strobe advances the base by the caller's local count and sets the callee's window to loc_i locals and out_i outputs, so the caller's first output register is the callee's r32.
- R5: A return strobe restores the caller's base, local count and output count saved by the matching call.
- R6: While resident caller slots plus the live window exceed 96, spill_req_o is high and xfer_idx_o names the oldest resident slot, (base - resident) mod 96; each spill_ack_i retires one slot, and the request drops once the window fits.
- R7: When a return finds fewer resident slots than the restored caller's locals, fill_req_o is high once per missing slot, xfer_idx_o stepping downward mod 96 from the slot just below the resident ones; spill and fill requests never coincide.
- R8: While busy_o is high, call, return and allocate strobes are ignored.
- R9: A call with the saved-frame LIFO full, or a return with it empty, is ignored.
- R10: When call and return strobes arrive in the same cycle, only the call takes effect; allocate has the lowest priority.
- R11: A call or allocate whose loc_i + out_i exceeds 96 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Procedure call strobe |
| ret_i | input | 1 | Procedure return strobe |
| alloc_i | input | 1 | Resize strobe for the current window |
| loc_i | input | 7 | Local register count for call or allocate |
| out_i | input | 7 | Output register count for call or allocate |
| vreg_i | input | 7 | Virtual register number to translate |
| phys_o | output | 7 | Physical register number (0..31 static, 32..127 stacked) |
| illegal_o | output | 1 | Virtual register lies beyond the live window |
| busy_o | output | 1 | A spill or fill is pending; operations stall |
| spill_req_o | output | 1 | Request to write one slot to memory |
| fill_req_o | output | 1 | Request to read one slot back from memory |
| xfer_idx_o | output | 7 | Ring slot (0..95) for the pending transfer |
| spill_ack_i | input | 1 | Spill of the named slot is done |
| fill_ack_i | input | 1 | Fill of the named slot is done |

## Verification
The call and return strobes can land in the same cycle, and a strobe can also land while a spill is still waiting for its acknowledge. The bench raises both strobes together and judges the outcome from translation alone: the base must have moved by the caller's locals and the window must have the call's size, not the popped caller's. It likewise issues an allocate in the middle of a spill run and checks through translation that the window size is still the one the call set.

// File: rtl/regstack_pkg.sv
package regstack_pkg;
  localparam int REG_W      = 7;
  localparam int NUM_STATIC = 32;
  localparam int NUM_STACK  = (2 ** REG_W) - NUM_STATIC;
  localparam int SW         = REG_W + 1;

  typedef logic [REG_W-1:0] reg_t;
  typedef logic [SW-1:0]    wide_t;

  localparam wide_t STACK_N  = wide_t'(NUM_STACK);
  localparam reg_t  STATIC_N = reg_t'(NUM_STATIC);

  typedef struct packed {
    reg_t base;
    reg_t nloc;
    reg_t nout;
  } frame_t;

  // a, b < NUM_STACK
  function automatic reg_t slot_add(reg_t a, reg_t b);
    wide_t s;
    s = wide_t'(a) + wide_t'(b);
    if (s >= STACK_N) s = s - STACK_N;
    return reg_t'(s);
  endfunction

  // a < NUM_STACK, b <= NUM_STACK
  function automatic reg_t slot_sub(reg_t a, wide_t b);
    wide_t s;
    s = wide_t'(a) + STACK_N - b;
    if (s >= STACK_N) s = s - STACK_N;
    return reg_t'(s);
  endfunction
endpackage

// File: rtl/regstack_frame_lifo.sv
module regstack_frame_lifo
  import regstack_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   push_i,
  input  logic   pop_i,
  input  frame_t din_i,
  output frame_t top_o,
  output logic   full_o,
  output logic   empty_o
);
  localparam int PW    = $clog2(DEPTH + 1);
  localparam int SLOTS = 2 ** PW;

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] top_idx;
  frame_t        mem_q [SLOTS];

  assign full_o  = (cnt_q == PW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign top_idx = cnt_q - PW'(1);
  assign top_o   = empty_o ? '0 : mem_q[top_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (push_i && !full_o) cnt_q <= cnt_q + PW'(1);
    else if (pop_i && !empty_o) cnt_q <= cnt_q - PW'(1);
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) mem_q[cnt_q] <= din_i;
  end

  assert_no_push_full_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_no_pop_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  assert_push_fills_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> !empty_o);
endmodule

// File: rtl/regstack_xlate.sv
module regstack_xlate
  import regstack_pkg::*;
(
  input  reg_t  vreg_i,
  input  reg_t  base_i,
  input  wide_t size_i,
  output reg_t  phys_o,
  output logic  illegal_o
);
  logic stacked;
  reg_t off;

  assign stacked   = (vreg_i >= STATIC_N);
  assign off       = vreg_i - STATIC_N;
  assign phys_o    = stacked ? (STATIC_N + slot_add(base_i, off)) : vreg_i;
  assign illegal_o = stacked && (wide_t'(off) >= size_i);
endmodule

// File: rtl/regstack_alloc.sv
module regstack_alloc
  import regstack_pkg::*;
#(
  parameter int FRAME_DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             call_i,
  input  logic             ret_i,
  input  logic             alloc_i,
  input  logic [REG_W-1:0] loc_i,
  input  logic [REG_W-1:0] out_i,
  input  logic [REG_W-1:0] vreg_i,
  output logic [REG_W-1:0] phys_o,
  output logic             illegal_o,
  output logic             busy_o,
  output logic             spill_req_o,
  output logic             fill_req_o,
  output logic [REG_W-1:0] xfer_idx_o,
  input  logic             spill_ack_i,
  input  logic             fill_ack_i
);
  reg_t   base_q, nloc_q, nout_q;
  reg_t   resident_q;   // caller slots still held in the ring
  reg_t   fill_left_q, fill_ptr_q;
  wide_t  size, occ, req_size;
  logic   req_ok, idle, call_go, ret_go, alloc_go;
  logic   lifo_full, lifo_empty;
  frame_t saved, cur_frame;

  assign size     = wide_t'(nloc_q) + wide_t'(nout_q);
  assign occ      = wide_t'(resident_q) + size;
  assign req_size = wide_t'(loc_i) + wide_t'(out_i);
  assign req_ok   = (req_size <= STACK_N);

  assign spill_req_o = (occ > STACK_N);
  assign fill_req_o  = (fill_left_q != '0);
  assign busy_o      = spill_req_o || fill_req_o;
  assign idle        = !busy_o;
  assign xfer_idx_o  = spill_req_o ? slot_sub(base_q, wide_t'(resident_q)) : fill_ptr_q;

  // priority: call, then return, then allocate
  assign call_go  = idle && call_i && !lifo_full && req_ok;
  assign ret_go   = idle && ret_i && !call_i && !lifo_empty;
  assign alloc_go = idle && alloc_i && !call_i && !ret_i && req_ok;

  assign cur_frame = '{base: base_q, nloc: nloc_q, nout: nout_q};

  regstack_frame_lifo #(.DEPTH(FRAME_DEPTH)) u_lifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (call_go),
    .pop_i   (ret_go),
    .din_i   (cur_frame),
    .top_o   (saved),
    .full_o  (lifo_full),
    .empty_o (lifo_empty)
  );

  regstack_xlate u_xlate (
    .vreg_i    (vreg_i),
    .base_i    (base_q),
    .size_i    (size),
    .phys_o    (phys_o),
    .illegal_o (illegal_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q      <= '0;
      nloc_q      <= '0;
      nout_q      <= '0;
      resident_q  <= '0;
      fill_left_q <= '0;
      fill_ptr_q  <= '0;
    end else if (call_go) begin
      base_q     <= slot_add(base_q, nloc_q);
      resident_q <= resident_q + nloc_q;
      nloc_q     <= loc_i;
      nout_q     <= out_i;
    end else if (ret_go) begin
      base_q <= saved.base;
      nloc_q <= saved.nloc;
      nout_q <= saved.nout;
      if (resident_q >= saved.nloc) begin
        resident_q <= resident_q - saved.nloc;
      end else begin
        resident_q  <= '0;
        fill_left_q <= saved.nloc - resident_q;
        fill_ptr_q  <= slot_sub(slot_sub(base_q, wide_t'(resident_q)), wide_t'(1));
      end
    end else if (alloc_go) begin
      nloc_q <= loc_i;
      nout_q <= out_i;
    end else if (spill_req_o && spill_ack_i) begin
      resident_q <= resident_q - reg_t'(1);
    end else if (fill_req_o && fill_ack_i) begin
      fill_left_q <= fill_left_q - reg_t'(1);
      fill_ptr_q  <= slot_sub(fill_ptr_q, wide_t'(1));
    end
  end

  assert_xfer_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spill_req_o |-> !fill_req_o);
  assert_spill_retires_one_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spill_req_o && spill_ack_i) |=> (resident_q == $past(resident_q) - reg_t'(1)));
  assert_fill_retires_one_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_o && fill_ack_i) |=> (fill_left_q == $past(fill_left_q) - reg_t'(1)));
  assert_busy_freezes_frame_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(base_q) && $stable(nloc_q) && $stable(nout_q)));
  assert_fill_no_spill_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_o |=> !spill_req_o);
endmodule

// File: tb/regstack_alloc_test.sv
`timescale 1ns/1ps
module regstack_alloc_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       call = 1'b0, ret = 1'b0, alloc = 1'b0;
  logic [6:0] loc = '0, outc = '0, vreg = '0;
  logic [6:0] phys, xfer_idx;
  logic       illegal, busy, spill_req, fill_req;
  logic       spill_ack = 1'b0, fill_ack = 1'b0;
  int         total = 0, bad = 0;

  always #10 clk = ~clk;

  regstack_alloc uut (
    .clk_i(clk), .rst_ni(rst_n), .call_i(call), .ret_i(ret), .alloc_i(alloc),
    .loc_i(loc), .out_i(outc), .vreg_i(vreg), .phys_o(phys), .illegal_o(illegal),
    .busy_o(busy), .spill_req_o(spill_req), .fill_req_o(fill_req),
    .xfer_idx_o(xfer_idx), .spill_ack_i(spill_ack), .fill_ack_i(fill_ack)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic xl(input int v, input int ep, input int eill, input string req);
    vreg = 7'(v);
    #1;
    chk(req, int'(illegal), eill);
    if (eill == 0) chk(req, int'(phys), ep);
  endtask

  task automatic op(input bit c, input bit r, input bit a, input int l, input int o);
    @(negedge clk);
    call = c; ret = r; alloc = a; loc = 7'(l); outc = 7'(o);
    @(negedge clk);
    call = 0; ret = 0; alloc = 0;
  endtask

  task automatic spills(input int n, input int first, input string req);
    for (int i = 0; i < n; i++) begin
      chk(req, int'(spill_req), 1);
      chk(req, int'(xfer_idx), (first + i) % 96);
      spill_ack = 1;
      @(negedge clk);
      spill_ack = 0;
    end
    chk(req, int'(spill_req), 0);
  endtask

  task automatic fills(input int n, input int first, input string req);
    for (int i = 0; i < n; i++) begin
      chk(req, int'(fill_req), 1);
      chk(req, int'(spill_req), 0);
      chk(req, int'(xfer_idx), (first - i + 96) % 96);
      fill_ack = 1;
      @(negedge clk);
      fill_ack = 0;
    end
    chk(req, int'(fill_req), 0);
    chk(req, int'(busy), 0);
  endtask

  task automatic t_reset();
    xl(0, 0, 0, "R1");
    xl(31, 31, 0, "R1");
    xl(32, 0, 1, "R1");
    chk("R1", int'(busy), 0);
  endtask

  task automatic t_call_ret();
    op(0, 0, 1, 10, 6);
    xl(32, 32, 0, "R3");
    xl(47, 47, 0, "R2");
    xl(48, 0, 1, "R2");
    op(1, 0, 0, 20, 5);               // base 10
    xl(32, 42, 0, "R4");
    xl(56, 66, 0, "R4");
    xl(57, 0, 1, "R4");
    chk("R4", int'(busy), 0);
    op(0, 1, 0, 0, 0);
    xl(32, 32, 0, "R5");
    xl(47, 47, 0, "R5");
    xl(48, 0, 1, "R5");
  endtask

  task automatic t_spill_fill();
    op(1, 0, 0, 90, 0);               // base 10, resident 10, occ 100
    chk("R6", int'(busy), 1);
    op(0, 0, 1, 1, 0);                // dropped while busy
    xl(121, 35, 0, "R8");
    xl(122, 0, 1, "R8");
    spills(4, 0, "R6");
    chk("R6", int'(busy), 0);
    xl(32, 42, 0, "R6");
    op(0, 1, 0, 0, 0);                // 6 resident, 10 needed
    fills(4, 3, "R7");
    xl(41, 41, 0, "R7");
  endtask

  task automatic t_wrap();
    op(0, 0, 1, 90, 6);               // exactly 96
    chk("R6", int'(spill_req), 0);
    op(1, 0, 0, 2, 0);                // base 90
    xl(32, 122, 0, "R2");
    xl(33, 123, 0, "R2");
    op(0, 0, 1, 10, 0);               // occ 100
    spills(4, 0, "R6");
    xl(41, 35, 0, "R2");
    op(0, 1, 0, 0, 0);                // 86 resident, 90 needed
    fills(4, 3, "R7");
    xl(127, 127, 0, "R5");
  endtask

  task automatic t_lifo_limits();
    op(0, 0, 1, 1, 1);
    for (int i = 0; i < 4; i++) op(1, 0, 0, 1, 1);
    xl(32, 36, 0, "R9");
    op(1, 0, 0, 3, 3);                // full: dropped
    xl(32, 36, 0, "R9");
    xl(34, 0, 1, "R9");
    for (int i = 0; i < 4; i++) op(0, 1, 0, 0, 0);
    xl(33, 33, 0, "R9");
    xl(34, 0, 1, "R9");
    op(0, 1, 0, 0, 0);                // empty: dropped
    xl(32, 32, 0, "R9");
    xl(33, 33, 0, "R9");
    xl(34, 0, 1, "R9");
  endtask

  task automatic t_collide();
    op(1, 1, 1, 4, 0);
    xl(32, 33, 0, "R10");
    xl(35, 36, 0, "R10");
    xl(36, 0, 1, "R10");
    op(0, 1, 0, 0, 0);
    xl(33, 33, 0, "R10");
    xl(34, 0, 1, "R10");
  endtask

  task automatic t_oversize();
    op(0, 0, 1, 90, 7);
    xl(33, 33, 0, "R11");
    xl(34, 0, 1, "R11");
    op(1, 0, 0, 96, 1);
    xl(32, 32, 0, "R11");
    xl(34, 0, 1, "R11");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_call_ret();
    t_spill_fill();
    t_wrap();
    t_lifo_limits();
    t_collide();
    t_oversize();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule